// File: doc/BRIEF.md
# Banked GPIO Data and Direction Register Port

This block is a memory-mapped general-purpose I/O port that groups its pins into banks of 32. Each bank owns a small window of word registers: a direction register, an output latch, two strobe addresses that set or clear latch bits without a read-modify-write, and an input register that returns the synchronised pad level. Software reaches the registers through a plain 32-bit word-addressed write/read port. The pad side of every pin carries an output value, an output enable and an incoming level.

Each bank window is ten words long. The last five words of a window are held for edge-interrupt control and status. They decode as part of the map but hold nothing, so the bank layout stays compatible with software that expects the full window. Reads on the bus are combinational from the current address. Writes take effect on the next rising clock edge.

Top module: `gpio_banked_port`

## Requirements
- R1: Pin p belongs to bank p/32 at bit p%32. Bank b occupies word addresses BASE_WORD+STRIDE_WORD*b onward (defaults 4 and 10). Inside a bank, word offset 0 is direction, 1 is output data, 2 is set-strobe, 3 is clear-strobe and 4 is input data. A write reaches at most one bank.
- R2: After reset every direction bit is 1, the output latch is all zero, pad_oe is all zero and the input registers read zero.
- R3: A direction bit of 1 makes its pin an input (pad_oe bit 0). A bit of 0 enables the pad driver (pad_oe bit 1). The direction register reads back as written and changes only when its own address is written.
- R4: A write to the set-strobe offset sets each latch bit whose write-data bit is 1 and leaves the others unchanged. The change shows on pad_out after the next rising edge.
- R5: A write to the clear-strobe offset clears each latch bit whose write-data bit is 1 and leaves the others unchanged.
- R6: A write to the output-data offset loads the whole latch. pad_out always shows the latch, whatever the direction.
- R7: Reads of the output-data, set-strobe and clear-strobe offsets all return the current latch value.
- R8: The input-data offset returns pad_in through a two-stage synchroniser. A level present at rising edge k becomes readable after edge k+1. This holds for pins configured as outputs too.
- R9: Word offsets 5 to 9 of a bank, and addresses outside all banks, read as zero. Writes to them change no register and no pad output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register and synchroniser clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the addressed word |
| bus_addr | input | ADDR_W (8) | Word address |
| bus_wdata | input | BANK_W (32) | Write data or set/clear mask |
| bus_rdata | output | BANK_W (32) | Read data for bus_addr |
| pad_in | input | NUM_BANKS*BANK_W (160) | Incoming pin levels |
| pad_out | output | NUM_BANKS*BANK_W (160) | Output latch per pin |
| pad_oe | output | NUM_BANKS*BANK_W (160) | Output driver enable per pin |

## Verification
A corrupted latch or direction bit shows on pad_out or pad_oe within one clock of the faulty write. It stays visible there until that bit is written again, so checking the pads on every cycle catches it at once. A wrong bank or offset decode shows as a write landing in a neighbouring bank or in a reserved word, and as a read that returns the wrong word. A synchroniser that is one stage short or long shows as readback of pad_in that is a cycle early or late whenever the pins toggle.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
   typedef logic [3:0] reg_idx_t;
   localparam reg_idx_t REG_DIR = 4'd0;
   localparam reg_idx_t REG_LAT = 4'd1;
   localparam reg_idx_t REG_SET = 4'd2;
   localparam reg_idx_t REG_CLR = 4'd3;
   localparam reg_idx_t REG_INP = 4'd4;
   localparam int       REG_USED = 10;
endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
   import gpio_bank_pkg::*;
#(
   parameter int NUM_BANKS   = 5,
   parameter int ADDR_W      = 8,
   parameter int BASE_WORD   = 4,
   parameter int STRIDE_WORD = 10,
   parameter int BSEL_W      = 3
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              hit,
   output logic [BSEL_W-1:0] bank_sel,
   output reg_idx_t          reg_sel
);
   localparam int SPAN = NUM_BANKS * STRIDE_WORD;

   logic [ADDR_W-1:0] rel;
   logic              above_base;

   assign above_base = addr >= ADDR_W'(BASE_WORD);
   assign rel        = addr - ADDR_W'(BASE_WORD);

   always_comb begin
      hit      = above_base && ({1'b0, rel} < (ADDR_W+1)'(SPAN));
      bank_sel = BSEL_W'(rel / ADDR_W'(STRIDE_WORD));
      reg_sel  = reg_idx_t'(rel % ADDR_W'(STRIDE_WORD));
   end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_in,
   output logic [W-1:0] q_out
);
   logic [W-1:0] stg [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[0] <= '0;
               else        stg[0] <= d_in;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[s] <= '0;
               else        stg[s] <= stg[s-1];
            end
         end
      end
   endgenerate

   assign q_out = stg[STAGES-1];
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
   import gpio_bank_pkg::*;
#(
   parameter int W           = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  reg_idx_t     reg_sel,
   input  logic [W-1:0] wdata,
   input  logic [W-1:0] pad_in,
   output logic [W-1:0] dir_q,
   output logic [W-1:0] lat_q,
   output logic [W-1:0] rd_word
);
   logic [W-1:0] in_sync;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q <= '1;
         lat_q <= '0;
      end else if (wr_en) begin
         case (reg_sel)
            REG_DIR: dir_q <= wdata;
            REG_LAT: lat_q <= wdata;
            REG_SET: lat_q <= lat_q | wdata;
            REG_CLR: lat_q <= lat_q & ~wdata;
            default: ;
         endcase
      end
   end

   gpio_in_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  (pad_in),
      .q_out (in_sync)
   );

   always_comb begin
      case (reg_sel)
         REG_DIR:                   rd_word = dir_q;
         REG_LAT, REG_SET, REG_CLR: rd_word = lat_q;
         REG_INP:                   rd_word = in_sync;
         default:                   rd_word = '0;
      endcase
   end

   // R4
   set_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && reg_sel == REG_SET) |=>
         ((lat_q & $past(wdata)) == $past(wdata)) &&
         ((lat_q & ~$past(wdata)) == ($past(lat_q) & ~$past(wdata))));
   // R5
   clr_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && reg_sel == REG_CLR) |=>
         ((lat_q & $past(wdata)) == '0) &&
         ((lat_q & ~$past(wdata)) == ($past(lat_q) & ~$past(wdata))));
   // R6
   load_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && reg_sel == REG_LAT) |=> lat_q == $past(wdata));
   // R3
   dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && reg_sel == REG_DIR) |=> $stable(dir_q));
   // R9
   rsvd_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && reg_sel > REG_INP) |=> $stable(dir_q) && $stable(lat_q));
endmodule

// File: rtl/gpio_banked_port.sv
module gpio_banked_port
   import gpio_bank_pkg::*;
#(
   parameter int NUM_BANKS   = 5,
   parameter int BANK_W      = 32,
   parameter int ADDR_W      = 8,
   parameter int BASE_WORD   = 4,
   parameter int STRIDE_WORD = 10,
   parameter int SYNC_STAGES = 2
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        bus_wr,
   input  logic [ADDR_W-1:0]           bus_addr,
   input  logic [BANK_W-1:0]           bus_wdata,
   output logic [BANK_W-1:0]           bus_rdata,
   input  logic [NUM_BANKS*BANK_W-1:0] pad_in,
   output logic [NUM_BANKS*BANK_W-1:0] pad_out,
   output logic [NUM_BANKS*BANK_W-1:0] pad_oe
);
   localparam int BSEL_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

   generate
      if (NUM_BANKS < 1) begin : g_bad_banks
         $error("NUM_BANKS must be at least one");
      end
      if (STRIDE_WORD < REG_USED || STRIDE_WORD > 16) begin : g_bad_stride
         $error("STRIDE_WORD must lie in 10..16");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least two");
      end
      if (BASE_WORD + NUM_BANKS * STRIDE_WORD > (1 << ADDR_W)) begin : g_bad_addr
         $error("ADDR_W too narrow for the bank map");
      end
   endgenerate

   logic              hit;
   logic [BSEL_W-1:0] bank_sel;
   reg_idx_t          reg_sel;
   logic [NUM_BANKS-1:0] bank_wr;
   logic [BANK_W-1:0] rd_word [NUM_BANKS];

   gpio_addr_decode #(
      .NUM_BANKS   (NUM_BANKS),
      .ADDR_W      (ADDR_W),
      .BASE_WORD   (BASE_WORD),
      .STRIDE_WORD (STRIDE_WORD),
      .BSEL_W      (BSEL_W)
   ) u_dec (
      .addr     (bus_addr),
      .hit      (hit),
      .bank_sel (bank_sel),
      .reg_sel  (reg_sel)
   );

   generate
      for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
         logic [BANK_W-1:0] dir_b;
         logic [BANK_W-1:0] lat_b;

         assign bank_wr[b] = bus_wr && hit && (bank_sel == BSEL_W'(b));

         gpio_bank_regs #(.W(BANK_W), .SYNC_STAGES(SYNC_STAGES)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (bank_wr[b]),
            .reg_sel (reg_sel),
            .wdata   (bus_wdata),
            .pad_in  (pad_in[b*BANK_W +: BANK_W]),
            .dir_q   (dir_b),
            .lat_q   (lat_b),
            .rd_word (rd_word[b])
         );

         assign pad_out[b*BANK_W +: BANK_W] = lat_b;
         assign pad_oe [b*BANK_W +: BANK_W] = ~dir_b;
      end
   endgenerate

   always_comb begin
      bus_rdata = '0;
      for (int b = 0; b < NUM_BANKS; b++) begin
         if (hit && bank_sel == BSEL_W'(b)) bus_rdata = rd_word[b];
      end
   end

   // R1
   one_bank_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(bank_wr));
   // R9
   miss_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !hit) |=> $stable(pad_out) && $stable(pad_oe));
endmodule

// File: tb/gpio_banked_port_bench.sv
module gpio_banked_port_bench;
   localparam int PERIOD = 10;
   localparam int NB = 5;
   localparam int BW = 32;
   localparam int NP = NB * BW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_wr = 1'b0;
   logic [7:0]    bus_addr = '0;
   logic [BW-1:0] bus_wdata = '0;
   logic [BW-1:0] bus_rdata;
   logic [NP-1:0] pad_in = '0;
   logic [NP-1:0] pad_out;
   logic [NP-1:0] pad_oe;

   int total = 0;
   int bad = 0;

   logic [BW-1:0] m_dir [NB];
   logic [BW-1:0] m_lat [NB];
   logic [NP-1:0] m_s1, m_s2;

   always #(PERIOD/2) clk = ~clk;

   gpio_banked_port u_gpio_banked_port (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
      .pad_out(pad_out), .pad_oe(pad_oe)
   );

   // behavioural reference, updated on each rising edge
   always @(posedge clk) begin
      if (!rst_n) begin
         for (int b = 0; b < NB; b++) begin m_dir[b] = '1; m_lat[b] = '0; end
         m_s1 = '0; m_s2 = '0;
      end else begin
         int a, bk, rg;
         a = int'(bus_addr);
         if (bus_wr && a >= 4 && a < 4 + NB*10) begin
            bk = (a - 4) / 10; rg = (a - 4) % 10;
            case (rg)
               0: m_dir[bk] = bus_wdata;
               1: m_lat[bk] = bus_wdata;
               2: m_lat[bk] = m_lat[bk] | bus_wdata;
               3: m_lat[bk] = m_lat[bk] & ~bus_wdata;
               default: ;
            endcase
         end
         m_s2 = m_s1;
         m_s1 = pad_in;
      end
   end

   task automatic chk(string req, logic [NP-1:0] act, logic [NP-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [BW-1:0] exp_rd(int a, output string tag);
      int bk, rg;
      tag = "R9";
      if (a < 4 || a >= 4 + NB*10) return '0;
      bk = (a - 4) / 10; rg = (a - 4) % 10;
      case (rg)
         0: begin tag = "R1"; return m_dir[bk]; end
         1: begin tag = "R6"; return m_lat[bk]; end
         2, 3: begin tag = "R7"; return m_lat[bk]; end
         4: begin tag = "R8"; return m_s2[bk*BW +: BW]; end
         default: return '0;
      endcase
   endfunction

   // compare on every falling edge
   always @(negedge clk) begin
      if (rst_n) begin
         logic [NP-1:0] eo, ee;
         string tg;
         logic [BW-1:0] er;
         for (int b = 0; b < NB; b++) begin
            eo[b*BW +: BW] = m_lat[b];
            ee[b*BW +: BW] = ~m_dir[b];
         end
         chk("R4/R5/R6 pad_out", pad_out, eo);
         chk("R3 pad_oe", pad_oe, ee);
         er = exp_rd(int'(bus_addr), tg);
         chk({tg, " rdata"}, NP'(bus_rdata), NP'(er));
      end
   end

   task automatic drive(bit wr, int a, logic [BW-1:0] d);
      @(posedge clk); #1;
      bus_wr = wr; bus_addr = 8'(a); bus_wdata = d;
   endtask

   initial begin
      #(PERIOD * 200000);
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R2 explicit reset values
      chk("R2 oe", pad_oe, '0);
      chk("R2 out", pad_out, '0);
      // R1 distinct per-bank direction patterns
      for (int b = 0; b < NB; b++) drive(1, 4 + 10*b, 32'h1111_0000 * (b+1) + 32'(b));
      for (int b = 0; b < NB; b++) drive(0, 4 + 10*b, '0);
      // R3 outputs in low half of bank 1
      drive(1, 14, 32'hFFFF_0000);
      // R4 set, R5 clear, R6 load, R7 readback
      drive(1, 16, 32'h0000_A5A5);
      drive(1, 16, 32'h0F00_0000);
      drive(0, 16, '0);
      drive(1, 17, 32'h0000_0005);
      drive(0, 17, '0);
      drive(1, 15, 32'h1234_5678);
      drive(0, 15, '0);
      drive(1, 17, 32'hFFFF_FFFF);
      drive(1, 16, 32'h0000_0000);
      // R8 synchroniser latency, pin driven as output too
      pad_in = {NB{32'hDEAD_BEEF}};
      drive(0, 18, '0);
      drive(0, 18, '0);
      drive(0, 28, '0);
      pad_in = '0;
      drive(0, 18, '0);
      drive(0, 18, '0);
      // R9 reserved offsets and unmapped addresses
      for (int r = 5; r < 10; r++) drive(1, 14 + r, 32'hFFFF_FFFF);
      drive(1, 0, 32'hFFFF_FFFF);
      drive(1, 3, 32'hFFFF_FFFF);
      drive(1, 54, 32'hFFFF_FFFF);
      drive(1, 255, 32'hFFFF_FFFF);
      drive(0, 54, '0);
      // random traffic
      for (int i = 0; i < 4000; i++) begin
         if (i % 7 == 0) begin
            logic [NP-1:0] v;
            for (int k = 0; k < NB; k++) v[k*BW +: BW] = $urandom;
            pad_in = v;
         end
         drive(($urandom % 3) != 0, int'($urandom % 64), $urandom);
      end
      drive(0, 0, '0);
      @(negedge clk);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule